// File: doc/BRIEF.md
# GPIO Port Interrupt Controller

A general-purpose I/O port of `NPINS` pins (32 by default) behind a small word-addressed register interface. Software sets each pin's output value and direction. It reads back the synchronized pad levels. It chooses, per pin, which pad condition raises an interrupt. Pad inputs pass through a two-flop synchronizer. A detector then compares each synchronized level with its value one cycle earlier, so it can report both levels and edges.

Detected events are held in a sticky status word, which software clears by writing ones. A mask word chooses which held events may request service. The port drives two interrupt lines. One combines the enabled requests of the lower half of the pins and the other combines the upper half, so a system can route the two halves to separate handlers.

Each access takes one cycle. A strobe with write high updates the addressed word at the next clock edge. A strobe with write low loads the read data register at the next clock edge, and that register holds its value until the next read.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: While reset is low, and at the first clock edge after it, the data, direction, mask, both-edge, both trigger-config words and the read data register are 0. pad_oe, pad_out, irq_lo and irq_hi are 0. Status is held at 0 during reset.
- R2: Word addresses are: 0 output data, 1 direction, 2 pad level, 3 trigger config for the lower pins, 4 trigger config for the upper pins, 5 mask, 6 status, 7 both-edge select. A read strobe loads rd_data at the next edge with the value the addressed word held before that edge.
- R3: pad_oe equals the direction word and pad_out equals the output data word. Reading word 0 returns the written data value, not the pad level.
- R4: Word 2 returns the pad inputs delayed by two flops. A change on pad_in becomes visible to a read strobe issued two edges later, and not earlier.
- R5: Pin p takes a 2-bit trigger code from bits [2*(p mod NPINS/2)+1 : 2*(p mod NPINS/2)]. Pins below NPINS/2 use word 3 and the other pins use word 4. Code 0 means low level, 1 high level, 2 rising edge and 3 falling edge.
- R6: An edge is a difference between the synchronized level and its value one cycle earlier. The status bit for an edge on pad_in is set at the third clock edge after the pad changes.
- R7: When a pin's bit in word 7 is 1, that pin's status is set on every rising and every falling edge, and its trigger code has no effect.
- R8: A level trigger sets its status bit on every cycle the level holds. A bit cleared while the level persists is therefore set again.
- R9: Writing word 6 clears each status bit written as 1 and leaves bits written as 0 unchanged. Status bits never clear otherwise.
- R10: When an event and a clear hit the same status bit in the same cycle, the bit ends set.
- R11: irq_lo is the OR over the lower pins of (status AND mask), and irq_hi is the same OR over the upper pins. A mask bit of 1 enables its pin.
- R12: Writes to word 2 and to words 8 and above change nothing. Reads of words 8 and above return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | One-cycle access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (4) | Word address |
| bus_wdata | input | NPINS (32) | Write data |
| bus_rdata | output | NPINS (32) | Read data, loaded by a read strobe |
| pad_in | input | NPINS (32) | Asynchronous pad levels |
| pad_out | output | NPINS (32) | Output value to the pads |
| pad_oe | output | NPINS (32) | Output enable per pin |
| irq_lo | output | 1 | Combined interrupt for the lower pins |
| irq_hi | output | 1 | Combined interrupt for the upper pins |

## Verification
The assertions assume that bus_sel, bus_wr, bus_addr and bus_wdata are stable around each rising edge. They also assume that every event bit produced by the detector appears in status exactly one edge later, so pad_in may change freely and asynchronously. The bench changes all inputs only on falling edges. Its random stimulus covers the whole address space, including unmapped words and the read-only pad word, with arbitrary write data. Pad bits toggle at random at rates that produce both isolated edges and long-held levels.

// File: rtl/gpio_irq_pkg.sv
// Shared definitions for the GPIO interrupt controller.
// Assumes word addresses are compared after zero-extension to 32 bits.
package gpio_irq_pkg;

    typedef enum logic [1:0] {
        TRIG_LOW  = 2'd0,
        TRIG_HIGH = 2'd1,
        TRIG_RISE = 2'd2,
        TRIG_FALL = 2'd3
    } trig_code_e;

    localparam int unsigned W_OUT    = 0;
    localparam int unsigned W_DIR    = 1;
    localparam int unsigned W_PAD    = 2;
    localparam int unsigned W_CFG_LO = 3;
    localparam int unsigned W_CFG_HI = 4;
    localparam int unsigned W_MASK   = 5;
    localparam int unsigned W_STAT   = 6;
    localparam int unsigned W_BOTH   = 7;
    localparam int unsigned N_WORDS  = 8;

endpackage

// File: rtl/gpio_pad_sync.sv
// Two-flop synchronizer for the pad inputs.
// Assumes pad_i is asynchronous to clk. Each bit is synchronized on its own.
module gpio_pad_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pad_i,
    output logic [W-1:0] level_o
);

    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    // Shift the pad levels through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= pad_i;
            stage2 <= stage1;
        end
    end

    assign level_o = stage2;

endmodule

// File: rtl/gpio_trig_detect.sv
// Per-pin trigger detector. It compares the synchronized level with the
// previous cycle's level and applies each pin's 2-bit code or the both-edge
// override.
// Assumes the configuration words are stable registers.
module gpio_trig_detect
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] level_i,
    input  logic [NPINS-1:0] cfg_lo_i,
    input  logic [NPINS-1:0] cfg_hi_i,
    input  logic [NPINS-1:0] both_i,
    output logic [NPINS-1:0] evt_o
);

    localparam int HALF = NPINS / 2;

    logic [NPINS-1:0] level_q;
    logic [NPINS-1:0] rise;
    logic [NPINS-1:0] fall;

    // Keep the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) level_q <= '0;
        else        level_q <= level_i;
    end

    assign rise = level_i & ~level_q;
    assign fall = ~level_i & level_q;

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        localparam int FB = 2 * (i % HALF);
        logic [1:0] code;
        logic       hit;

        if (i < HALF) begin : g_lo
            assign code = cfg_lo_i[FB +: 2];
        end else begin : g_hi
            assign code = cfg_hi_i[FB +: 2];
        end

        // Decide whether this pin has an event this cycle.
        always_comb begin
            if (both_i[i]) begin
                hit = rise[i] | fall[i];
            end else begin
                unique case (trig_code_e'(code))
                    TRIG_LOW:  hit = ~level_i[i];
                    TRIG_HIGH: hit = level_i[i];
                    TRIG_RISE: hit = rise[i];
                    TRIG_FALL: hit = fall[i];
                    default:   hit = 1'b0;
                endcase
            end
        end

        assign evt_o[i] = hit;
    end

endmodule

// File: rtl/gpio_regs.sv
// Register file: output data, direction, trigger config, mask, both-edge
// select and the sticky status word. The read data is registered.
// Assumes one access per strobe cycle. An event beats a clear to the same bit.
module gpio_regs
    import gpio_irq_pkg::*;
#(
    parameter int NPINS  = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [NPINS-1:0]  wdata_i,
    output logic [NPINS-1:0]  rdata_o,
    input  logic [NPINS-1:0]  level_i,
    input  logic [NPINS-1:0]  evt_i,
    output logic [NPINS-1:0]  out_o,
    output logic [NPINS-1:0]  dir_o,
    output logic [NPINS-1:0]  cfg_lo_o,
    output logic [NPINS-1:0]  cfg_hi_o,
    output logic [NPINS-1:0]  mask_o,
    output logic [NPINS-1:0]  both_o,
    output logic [NPINS-1:0]  stat_o
);

    localparam logic [ADDR_W-1:0] A_OUT    = ADDR_W'(W_OUT);
    localparam logic [ADDR_W-1:0] A_DIR    = ADDR_W'(W_DIR);
    localparam logic [ADDR_W-1:0] A_PAD    = ADDR_W'(W_PAD);
    localparam logic [ADDR_W-1:0] A_CFG_LO = ADDR_W'(W_CFG_LO);
    localparam logic [ADDR_W-1:0] A_CFG_HI = ADDR_W'(W_CFG_HI);
    localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(W_MASK);
    localparam logic [ADDR_W-1:0] A_STAT   = ADDR_W'(W_STAT);
    localparam logic [ADDR_W-1:0] A_BOTH   = ADDR_W'(W_BOTH);

    logic             wr_en;
    logic             rd_en;
    logic             wr_stat;
    logic [NPINS-1:0] clr;
    logic [NPINS-1:0] rd_mux;

    assign wr_en   = sel_i & wr_i;
    assign rd_en   = sel_i & ~wr_i;
    assign wr_stat = wr_en && (addr_i == A_STAT);
    assign clr     = wr_stat ? wdata_i : '0;

    // Update the configuration registers on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_o    <= '0;
            dir_o    <= '0;
            cfg_lo_o <= '0;
            cfg_hi_o <= '0;
            mask_o   <= '0;
            both_o   <= '0;
        end else if (wr_en) begin
            unique case (addr_i)
                A_OUT:    out_o    <= wdata_i;
                A_DIR:    dir_o    <= wdata_i;
                A_CFG_LO: cfg_lo_o <= wdata_i;
                A_CFG_HI: cfg_hi_o <= wdata_i;
                A_MASK:   mask_o   <= wdata_i;
                A_BOTH:   both_o   <= wdata_i;
                default:  ;
            endcase
        end
    end

    // Sticky status: write-one clears, and a new event wins over the clear.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_o <= '0;
        else        stat_o <= (stat_o & ~clr) | evt_i;
    end

    // Select the addressed word. Unmapped words read as zero.
    always_comb begin
        unique case (addr_i)
            A_OUT:    rd_mux = out_o;
            A_DIR:    rd_mux = dir_o;
            A_PAD:    rd_mux = level_i;
            A_CFG_LO: rd_mux = cfg_lo_o;
            A_CFG_HI: rd_mux = cfg_hi_o;
            A_MASK:   rd_mux = mask_o;
            A_STAT:   rd_mux = stat_o;
            A_BOTH:   rd_mux = both_o;
            default:  rd_mux = '0;
        endcase
    end

    // Register the read data on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata_o <= '0;
        else if (rd_en) rdata_o <= rd_mux;
    end

    // A status bit never drops unless status is written.
    assert_status_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stat |=> (($past(stat_o) & ~stat_o) == '0));

    // A written one clears the bit unless an event hit it in the same cycle.
    assert_w1c_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stat |=> ((stat_o & $past(wdata_i) & ~$past(evt_i)) == '0));

    // Every detector event is held in status at the next edge.
    assert_event_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i != '0) |=> ((stat_o & $past(evt_i)) == $past(evt_i)));

    // Writes to the pad word or to unmapped words leave every register unchanged.
    assert_ignored_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ((32'(addr_i) >= N_WORDS) || (addr_i == A_PAD)))
        |=> ($stable(out_o) && $stable(dir_o) && $stable(cfg_lo_o) &&
             $stable(cfg_hi_o) && $stable(mask_o) && $stable(both_o)));

endmodule

// File: rtl/gpio_irq_ctrl.sv
// GPIO port with per-pin interrupt detection and two combined interrupt
// lines, one for each half of the pins.
// Assumes NPINS is even and ADDR_W is at least 3. Bus inputs are synchronous to clk.
module gpio_irq_ctrl #(
    parameter int NPINS  = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe,
    output logic              irq_lo,
    output logic              irq_hi
);

    localparam int HALF = NPINS / 2;

    logic [NPINS-1:0] level;
    logic [NPINS-1:0] evt;
    logic [NPINS-1:0] cfg_lo;
    logic [NPINS-1:0] cfg_hi;
    logic [NPINS-1:0] both;
    logic [NPINS-1:0] mask;
    logic [NPINS-1:0] stat;
    logic [NPINS-1:0] req;

    gpio_pad_sync #(.W(NPINS)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pad_i   (pad_in),
        .level_o (level)
    );

    gpio_trig_detect #(.NPINS(NPINS)) u_detect (
        .clk      (clk),
        .rst_n    (rst_n),
        .level_i  (level),
        .cfg_lo_i (cfg_lo),
        .cfg_hi_i (cfg_hi),
        .both_i   (both),
        .evt_o    (evt)
    );

    gpio_regs #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_i    (bus_sel),
        .wr_i     (bus_wr),
        .addr_i   (bus_addr),
        .wdata_i  (bus_wdata),
        .rdata_o  (bus_rdata),
        .level_i  (level),
        .evt_i    (evt),
        .out_o    (pad_out),
        .dir_o    (pad_oe),
        .cfg_lo_o (cfg_lo),
        .cfg_hi_o (cfg_hi),
        .mask_o   (mask),
        .both_o   (both),
        .stat_o   (stat)
    );

    // Combine the enabled requests of each half into its own line.
    assign req    = stat & mask;
    assign irq_lo = |req[HALF-1:0];
    assign irq_hi = |req[NPINS-1:HALF];

    // The lower line can only rise with a lower mask bit set.
    assert_irq_lo_masked_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_lo |-> (mask[HALF-1:0] != '0));

    // The upper line can only rise with an upper mask bit set.
    assert_irq_hi_masked_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_hi |-> (mask[NPINS-1:HALF] != '0));

endmodule

// File: tb/tb_gpio_irq_ctrl.sv
module tb_gpio_irq_ctrl;

    localparam int NP = 32;
    localparam int AW = 4;
    localparam int HF = NP / 2;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          bus_sel;
    logic          bus_wr;
    logic [AW-1:0] bus_addr;
    logic [NP-1:0] bus_wdata;
    logic [NP-1:0] bus_rdata;
    logic [NP-1:0] pad_in;
    logic [NP-1:0] pad_out;
    logic [NP-1:0] pad_oe;
    logic          irq_lo;
    logic          irq_hi;

    always #10 clk = ~clk;

    gpio_irq_ctrl #(.NPINS(NP), .ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .irq_lo(irq_lo), .irq_hi(irq_hi)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Reference state built from the requirements
    logic [NP-1:0] m_out, m_dir, m_clo, m_chi, m_mask, m_stat, m_both;
    logic [NP-1:0] m_s1, m_s2, m_prev, m_rd;

    function automatic logic [NP-1:0] f_events(input logic [NP-1:0] lvl,
            input logic [NP-1:0] prv, input logic [NP-1:0] clo,
            input logic [NP-1:0] chi, input logic [NP-1:0] bth);
        logic [NP-1:0] ev;
        for (int i = 0; i < NP; i++) begin
            logic [1:0] code;
            code = (i < HF) ? clo[2*i +: 2] : chi[2*(i-HF) +: 2];
            if (bth[i]) ev[i] = lvl[i] ^ prv[i];
            else case (code)
                2'd0: ev[i] = ~lvl[i];
                2'd1: ev[i] = lvl[i];
                2'd2: ev[i] = lvl[i] & ~prv[i];
                default: ev[i] = ~lvl[i] & prv[i];
            endcase
        end
        return ev;
    endfunction

    function automatic logic [NP-1:0] f_read(input logic [AW-1:0] a);
        case (a)
            4'd0: return m_out;
            4'd1: return m_dir;
            4'd2: return m_s2;
            4'd3: return m_clo;
            4'd4: return m_chi;
            4'd5: return m_mask;
            4'd6: return m_stat;
            4'd7: return m_both;
            default: return '0;
        endcase
    endfunction

    task automatic model_step();
        logic [NP-1:0] ev, nrd, clr;
        if (!rst_n) begin
            {m_out, m_dir, m_clo, m_chi, m_mask, m_stat, m_both} = '0;
            {m_s1, m_s2, m_prev, m_rd} = '0;
        end else begin
            ev  = f_events(m_s2, m_prev, m_clo, m_chi, m_both);
            nrd = (bus_sel && !bus_wr) ? f_read(bus_addr) : m_rd;
            clr = '0;
            if (bus_sel && bus_wr) begin
                case (bus_addr)
                    4'd0: m_out  = bus_wdata;
                    4'd1: m_dir  = bus_wdata;
                    4'd3: m_clo  = bus_wdata;
                    4'd4: m_chi  = bus_wdata;
                    4'd5: m_mask = bus_wdata;
                    4'd6: clr    = bus_wdata;
                    4'd7: m_both = bus_wdata;
                    default: ;
                endcase
            end
            m_stat = (m_stat & ~clr) | ev;
            m_rd   = nrd;
            m_prev = m_s2;
            m_s2   = m_s1;
            m_s1   = pad_in;
        end
    endtask

    task automatic chk(input string tag, input logic [NP-1:0] act, input logic [NP-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One clock: advance the model at the rising edge, compare at the falling edge
    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        chk("R3 pad_out", pad_out, m_out);
        chk("R3 pad_oe", pad_oe, m_dir);
        chk("R11 irq_lo", {31'd0, irq_lo}, {31'd0, |(m_stat[HF-1:0] & m_mask[HF-1:0])});
        chk("R11 irq_hi", {31'd0, irq_hi}, {31'd0, |(m_stat[NP-1:HF] & m_mask[NP-1:HF])});
        chk("R2 rdata", bus_rdata, m_rd);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) tick();
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [NP-1:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [NP-1:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        tick();
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog (R2 bus progress) actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [NP-1:0] v;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0;
        bus_wdata = '0; pad_in = '0;
        @(negedge clk);
        idle(4);
        rst_n = 1'b1;
        // R1: reset state visible at the outputs
        chk("R1 pad_oe", pad_oe, '0);
        chk("R1 pad_out", pad_out, '0);
        chk("R1 irq", {30'd0, irq_hi, irq_lo}, '0);
        chk("R1 rdata", bus_rdata, '0);
        rd(4'd0, v); chk("R1 data", v, '0);
        rd(4'd1, v); chk("R1 dir", v, '0);
        rd(4'd3, v); chk("R1 cfg_lo", v, '0);
        rd(4'd4, v); chk("R1 cfg_hi", v, '0);
        rd(4'd5, v); chk("R1 mask", v, '0);
        rd(4'd7, v); chk("R1 both", v, '0);

        // R9: switch everything to high level, then clear status
        wr(4'd3, 32'h5555_5555);
        wr(4'd4, 32'h5555_5555);
        idle(1);
        wr(4'd6, 32'hFFFF_FFFF);
        rd(4'd6, v); chk("R9 clear all", v, '0);
        wr(4'd5, 32'hFFFF_FFFF);

        // R5 R6: pin 17 rising edge through its field in the upper word
        wr(4'd4, 32'h5555_5559);
        rd(4'd4, v); chk("R2 cfg_hi readback", v, 32'h5555_5559);
        pad_in[17] = 1'b1;
        idle(1);
        chk("R6 no status after one edge", {31'd0, irq_hi}, '0);
        idle(2);
        rd(4'd6, v); chk("R5 R6 rising pin17", v, 32'h0002_0000);
        chk("R11 upper line", {30'd0, irq_hi, irq_lo}, 32'd2);

        // R9: a zero write keeps the bit, a one write clears it
        wr(4'd6, 32'h0000_0000);
        rd(4'd6, v); chk("R9 write zero", v, 32'h0002_0000);
        wr(4'd6, 32'h0002_0000);
        rd(4'd6, v); chk("R9 write one", v, '0);
        chk("R11 upper line low", {30'd0, irq_hi, irq_lo}, '0);

        // R8 R10: a held high level sets the bit again after a clear
        pad_in[3] = 1'b1;
        idle(3);
        wr(4'd6, 32'h0000_0008);
        rd(4'd6, v); chk("R8 R10 level reasserts", v, 32'h0000_0008);
        chk("R11 lower line", {30'd0, irq_hi, irq_lo}, 32'd1);
        pad_in[3] = 1'b0;
        idle(3);
        wr(4'd6, 32'h0000_0008);
        rd(4'd6, v); chk("R8 level gone", v, '0);

        // R7: the both-edge bit overrides the high-level code on pin 20
        wr(4'd7, 32'h0010_0000);
        pad_in[20] = 1'b1;
        idle(3);
        rd(4'd6, v); chk("R7 rise", v, 32'h0010_0000);
        wr(4'd6, 32'h0010_0000);
        idle(2);
        rd(4'd6, v); chk("R7 no level retrigger", v, '0);
        pad_in[20] = 1'b0;
        idle(3);
        rd(4'd6, v); chk("R7 fall", v, 32'h0010_0000);
        wr(4'd6, 32'hFFFF_FFFF);

        // R12: the pad word and unmapped words ignore writes
        wr(4'd2, 32'hFFFF_FFFF);
        wr(4'd9, 32'hFFFF_FFFF);
        rd(4'd9, v); chk("R12 unmapped read", v, '0);
        rd(4'd15, v); chk("R12 unmapped read top", v, '0);
        rd(4'd0, v); chk("R12 data untouched", v, '0);
        rd(4'd5, v); chk("R12 mask untouched", v, 32'hFFFF_FFFF);
        rd(4'd2, v); chk("R4 pad level", v, 32'h0002_0000);

        // R3: outputs follow data and direction, reads return the latch
        wr(4'd0, 32'hA5A5_0F0F);
        wr(4'd1, 32'hFFFF_0000);
        chk("R3 pad_out value", pad_out, 32'hA5A5_0F0F);
        chk("R3 pad_oe value", pad_oe, 32'hFFFF_0000);
        rd(4'd0, v); chk("R3 data not pad", v, 32'hA5A5_0F0F);

        // R4: two-flop latency on the pad word
        pad_in = 32'h1234_5678;
        rd(4'd2, v); chk("R4 latency 0", v, 32'h0002_0000);
        rd(4'd2, v); chk("R4 latency 1", v, 32'h0002_0000);
        rd(4'd2, v); chk("R4 latency 2", v, 32'h1234_5678);

        // Random phase over all words and pad activity
        for (int n = 0; n < 6000; n++) begin
            int unsigned r;
            r = $urandom_range(0, 99);
            if ((n % 500) < 250) pad_in = pad_in ^ ($urandom() & $urandom() & $urandom());
            else if (r < 5) pad_in = $urandom();
            if (r < 30) begin
                bus_sel = 1'b1; bus_wr = 1'b1;
                bus_addr = AW'($urandom_range(0, 15));
                bus_wdata = $urandom();
            end else if (r < 60) begin
                bus_sel = 1'b1; bus_wr = 1'b0;
                bus_addr = AW'($urandom_range(0, 15));
            end else begin
                bus_sel = 1'b0; bus_wr = 1'b0;
            end
            tick();
        end
        bus_sel = 1'b0;
        idle(2);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule